// File: doc/BRIEF.md
# MAC Local Pause Timer

This block stops the transmit queues of an Ethernet MAC for a set length of time when software asks for a local pause. Software writes one control word. The word carries a 16-bit pause length and a start flag. Writing the start flag loads the length into a down-counter at once and raises a halt request to the transmit queue logic.

The length is counted in quanta. One quantum is 512 receive bit times. The block takes a one-cycle bit-time strobe from the receive clocking logic. A prescaler counts these strobes, and each time 512 of them have passed, the quantum counter steps down by one. The halt request stays high until that counter reaches zero.

The halt output is only a request. Finishing a frame that is already in flight is left to the transmit logic. A start issued while a pause is running replaces that pause. A start with a zero length ends a running pause.

Top module: `lpause_timer`

## Requirements
- R1: The control word resets to 0. A write stores bits 15:0 as the pause length. A read returns the stored length in bits 15:0. The start flag (bit 16) and the reserved bits 31:17 always read 0.
- R2: A write with bit 16 set and a nonzero length raises `tx_halt` in the cycle after the write.
- R3: After a start with length L, `tx_halt` stays high for exactly L*512 bit-time strobes. It falls at the clock edge that samples the last of them.
- R4: Strobes that arrive while no pause is running are ignored. Every pause begins counting from a prescaler value of zero.
- R5: A start with length 0 raises no halt. If a pause is running, that start ends it in the next cycle.
- R6: A start during a running pause reloads the counter with the new length and restarts the prescaler. A strobe in the cycle of a start write is not counted.
- R7: A write with bit 16 clear only stores the length. It leaves a running pause unchanged, and it does not start one.
- R8: A synchronous, active-high reset clears the counter, the prescaler, the stored length and `tx_halt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 17 | Write data: length in 15:0, start flag in 16 |
| reg_rdata | output | 32 | Readback of the control word |
| bit_tick | input | 1 | One-cycle strobe per receive bit time |
| tx_halt | output | 1 | Request to hold off the transmit queues |

## Verification
The embedded assertions check the cycle-level rules on every cycle:
- the counter never rises except on a load, and it steps down by exactly one on each wrap;
- the prescaler returns to zero after a start or a wrap;
- a start raises or drops the halt in the next cycle, depending on its length;
- the stored length changes only on a write.

The total halt length in strobes, the behaviour at different strobe rates, the discarding of strobes while idle, and the reload and cancel cases can only be shown by the bench's scoreboard scenarios. The scoreboard measures each halt period in strobes and compares it with the length that was written.

// File: rtl/lpause_pkg.sv
package lpause_pkg;
  localparam int REG_W     = 32;
  localparam int LEN_W     = 16;
  localparam int START_POS = 16;
  localparam int WR_W      = START_POS + 1;
  localparam int QUANTUM   = 512;
endpackage

// File: rtl/lpause_ctrl_reg.sv
module lpause_ctrl_reg #(
  parameter int REG_W     = 32,
  parameter int LEN_W     = 16,
  parameter int START_POS = 16,
  localparam int WR_W     = START_POS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [WR_W-1:0]  wdata,
  output logic             start_pulse,
  output logic [LEN_W-1:0] load_len,
  output logic [REG_W-1:0] rdata
);
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else if (wr) len_q <= wdata[LEN_W-1:0];
  end

  // start flag is never stored: it acts in the write cycle only
  assign start_pulse = wr & wdata[START_POS];
  assign load_len    = wdata[LEN_W-1:0];
  assign rdata       = {{(REG_W-LEN_W){1'b0}}, len_q};

  assert_len_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr |=> len_q == $past(wdata[LEN_W-1:0]));
  assert_len_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(len_q));
endmodule

// File: rtl/lpause_prescaler.sv
module lpause_prescaler #(
  parameter int QUANTUM = 512,
  localparam int PRE_W  = (QUANTUM > 1) ? $clog2(QUANTUM) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic tick,
  output logic wrap
);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(QUANTUM - 1);
  logic [PRE_W-1:0] pre;

  assign wrap = run & tick & ~clr & (pre == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr || !run) pre <= '0;
    else if (tick) pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  assert_pre_clear_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> pre == '0);
  assert_pre_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> pre == '0);
endmodule

// File: rtl/lpause_down_counter.sv
module lpause_down_counter #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             halt
);
  logic [LEN_W-1:0] cnt, cnt_next;

  always_comb begin
    cnt_next = cnt;
    if (load) cnt_next = load_val;
    else if (dec && cnt != '0) cnt_next = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      halt <= 1'b0;
    end else begin
      cnt  <= cnt_next;
      halt <= (cnt_next != '0);
    end
  end

  assert_no_rise_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> cnt <= $past(cnt));
  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && dec && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!load && !dec) |=> $stable(cnt));
endmodule

// File: rtl/lpause_timer.sv
module lpause_timer
  import lpause_pkg::*;
#(
  parameter int QUANTUM_TICKS = QUANTUM
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [WR_W-1:0]  reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             bit_tick,
  output logic             tx_halt
);
  logic             start_pulse;
  logic [LEN_W-1:0] load_len;
  logic             quantum_done;

  lpause_ctrl_reg #(
    .REG_W(REG_W), .LEN_W(LEN_W), .START_POS(START_POS)
  ) u_reg (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .start_pulse(start_pulse), .load_len(load_len), .rdata(reg_rdata)
  );

  lpause_prescaler #(.QUANTUM(QUANTUM_TICKS)) u_pre (
    .clk(clk), .rst(rst), .clr(start_pulse), .run(tx_halt),
    .tick(bit_tick), .wrap(quantum_done)
  );

  lpause_down_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(start_pulse), .load_val(load_len),
    .dec(quantum_done), .halt(tx_halt)
  );

  assert_start_halts_R2: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && load_len != '0) |=> tx_halt);
  assert_zero_start_R5: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && load_len == '0) |=> !tx_halt);
  assert_idle_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (!tx_halt && !start_pulse) |=> !tx_halt);
endmodule

// File: tb/lpause_timer_tb.sv
module lpause_timer_tb;
  localparam int Q = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [16:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_raw = 1'b0;
  logic        bit_tick;
  logic        tx_halt;

  int checks = 0;
  int errors = 0;
  int tick_period = 0;
  int phase = 0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  // no strobe in a write cycle, so every counted strobe is a consumed one
  assign bit_tick = tick_raw & ~reg_wr;

  lpause_timer u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bit_tick(bit_tick), .tx_halt(tx_halt)
  );

  always @(negedge clk) begin
    if (tick_period == 0) begin
      tick_raw = 1'b0;
      phase = 0;
    end else begin
      tick_raw = (phase == 0);
      phase = (phase + 1 >= tick_period) ? 0 : phase + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: strobes consumed per halt period
  int seen = 0;
  bit prev_halt = 1'b0;
  always begin
    @(negedge clk);
    #2;
    if (rst) begin
      seen = 0;
      prev_halt = 1'b0;
    end else begin
      if (prev_halt && !tx_halt) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected halt end", seen, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(seen == e, t, seen, e);
        end
      end
      if (reg_wr && reg_wdata[16]) seen = 0;
      if (tx_halt && bit_tick) seen++;
      prev_halt = tx_halt;
    end
  end

  task automatic wr(input bit start, input int len);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = {start, 16'(len)};
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push(input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc && tx_halt; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_halt == 1'b0, "R8 reset halt", tx_halt, 0);
    check(reg_rdata == 32'h0, "R1 reset value", reg_rdata, 0);

    // R1 readback, start reads 0
    wr(1'b0, 16'hA5C3);
    check(reg_rdata == 32'h0000_A5C3, "R1 readback", reg_rdata, 32'hA5C3);
    check(tx_halt == 1'b0, "R7 no start without flag", tx_halt, 0);

    // R4 idle strobes ignored
    tick_period = 1;
    repeat (700) @(negedge clk);
    check(tx_halt == 1'b0, "R4 idle strobes", tx_halt, 0);

    // R2/R3 length 1, strobe every cycle
    push(1 * Q, "R3 len1 every cycle (R4 prescaler from zero)");
    wr(1'b1, 1);
    check(tx_halt == 1'b1, "R2 halt after start", tx_halt, 1);
    check(reg_rdata == 32'h1, "R1 start flag reads 0", reg_rdata, 1);
    wait_idle(2000);

    // R3 length 3, strobe every third cycle
    tick_period = 3;
    push(3 * Q, "R3 len3 slow strobes");
    wr(1'b1, 3);
    check(tx_halt == 1'b1, "R2 halt after start len3", tx_halt, 1);
    wait_idle(6000);

    // R5 zero length
    tick_period = 1;
    wr(1'b1, 0);
    check(tx_halt == 1'b0, "R5 zero length no halt", tx_halt, 0);
    repeat (20) @(negedge clk);
    check(tx_halt == 1'b0, "R5 zero length stays low", tx_halt, 0);

    // R6 reload during pause
    wr(1'b1, 2);
    repeat (300) @(negedge clk);
    push(1 * Q, "R6 reload counts new length");
    wr(1'b1, 1);
    check(tx_halt == 1'b1, "R6 halt kept on reload", tx_halt, 1);
    wait_idle(2000);

    // R7 non-start write during pause
    push(1 * Q, "R7 plain write leaves pause");
    wr(1'b1, 1);
    repeat (100) @(negedge clk);
    wr(1'b0, 5);
    check(reg_rdata == 32'h5, "R7 length stored", reg_rdata, 5);
    check(tx_halt == 1'b1, "R7 pause continues", tx_halt, 1);
    wait_idle(2000);

    // R5 cancel running pause
    wr(1'b1, 4);
    repeat (50) @(negedge clk);
    push(0, "R5 cancel");
    wr(1'b1, 0);
    check(tx_halt == 1'b0, "R5 cancel drops halt", tx_halt, 0);
    repeat (3) @(negedge clk);

    // R8 reset mid-pause
    wr(1'b1, 2);
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(tx_halt == 1'b0, "R8 reset mid pause", tx_halt, 0);
    check(reg_rdata == 32'h0, "R8 reset clears length", reg_rdata, 0);

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R3 all periods seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule